// File: doc/BRIEF.md
# Timer Channel Count Latch and Byte Readout

This block is one 16-bit down-counting channel of a programmable interval timer, as seen from an 8-bit processor bus. Software programs the channel with a control word. It then loads a starting count one byte at a time and reads the running count back one byte at a time. The counting clock `tmrClk` is sampled in the system clock domain. Each rising edge of `tmrClk` is one count step, and a step is taken only while `tmrGate` is high. Two counting behaviours are provided: a plain periodic count that steps by one, and a square-wave count that steps by two.

A reading taken straight from the running counter can change between the low and high byte reads. To avoid this, software issues a latch command. The command freezes a snapshot of the count without disturbing the counter, and reads return that snapshot until it has been fully read. Reads and writes keep separate byte pointers. A two-byte read can therefore be interleaved with a two-byte load and neither corrupts the other.

Top module: `timer_channel`

## Requirements
- R1: After reset the count is 0x0000, the read/load mode is low-then-high, both byte pointers point to the low byte and no snapshot is held, so two reads return 0x00 and then 0x00.
- R2: A control word is a write with `ctrlWr` high. Bits 7:6 must equal the channel number (default 1), or the whole word has no effect. Bits 5:4 select the action: 00 latch, 01 low byte only, 10 high byte only, 11 low then high. Bits 3:1 equal to 011 select square-wave counting, and any other value selects periodic counting. Bit 0 is ignored. Data strobes with `chanSel` low have no effect.
- R3: In periodic counting the count decreases by 1 on each sampled rising edge of `tmrClk` while `tmrGate` is high, and it wraps from 0x0000 to 0xFFFF.
- R4: In square-wave counting the count decreases by 2 on each such edge, modulo 65536.
- R5: While `tmrGate` is low, counting edges leave the count unchanged.
- R6: A latch command copies the present count into a snapshot without changing counting, and later reads return bytes of the snapshot.
- R7: A latch command that arrives while a snapshot is still unread is ignored, and the first snapshot is kept.
- R8: The snapshot is released after the final byte is read: the high byte in low-then-high mode, or the single byte in a one-byte mode. Reads after that return the live count.
- R9: In low-then-high mode, reads alternate between bits 7:0 and bits 15:8. In low-only mode every read returns bits 7:0, and in high-only mode every read returns bits 15:8.
- R10: A load in low-then-high mode takes the low byte and then the high byte. The new count replaces the count at the first `tmrClk` edge after the final byte, whatever the level of `tmrGate`. The low byte alone does not disturb the running count. One-byte modes load the written byte and zero the other byte.
- R11: The read pointer and the write pointer are independent. The sequence read low, write low, read high, write high returns the snapshot and loads the written count.
- R12: A control word with bits 5:4 not 00 resets both pointers to the low byte, releases any snapshot and cancels a load that has not yet been applied. The count keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuDataIn | input | 8 | Bus write data and control word |
| cpuDataOut | output | 8 | Byte selected for reading (valid while `rdStb` is high) |
| rdStb | input | 1 | Read strobe, one cycle per byte |
| wrStb | input | 1 | Data write strobe, one cycle per byte |
| chanSel | input | 1 | Selects this channel's data register |
| ctrlWr | input | 1 | Control word write strobe |
| tmrClk | input | 1 | Counting clock, sampled for rising edges |
| tmrGate | input | 1 | Count enable |

## Verification
The hardest state to reach is the overlap of a held snapshot, a half-finished read and a half-finished load. A latch command followed by further counting edges and a second latch command must still return the first value, with a low-byte write slipped between the two reads. Directed sequences build each of these overlaps explicitly, including a control word that arrives partway through a read and partway through a load. Random phases then mix latch commands, control words for other channels, byte writes and gated edges. Every read is compared against a bench model of the pointers and the snapshot.

// File: rtl/tmr_chan_pkg.sv
`timescale 1ns/1ps
package tmr_chan_pkg;

  typedef enum logic [1:0] {
    RL_LATCH = 2'b00,
    RL_LOW   = 2'b01,
    RL_HIGH  = 2'b10,
    RL_BOTH  = 2'b11
  } rlMode_e;

  typedef struct packed {
    logic captureSnap;
    logic holdLo;
    logic holdHi;
    logic clearOther;
    logic armLoad;
    logic cancelLoad;
    logic selSnap;
    logic readHigh;
    logic squareMode;
  } ctrlStrobes_t;

endpackage

// File: rtl/tmr_chan_ctrl.sv
`timescale 1ns/1ps
module tmr_chan_ctrl
  import tmr_chan_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W = 2,
  parameter logic [SEL_W-1:0] CHAN_ID = 1,
  parameter logic [2:0] SQUARE_CODE = 3'b011
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] cpuDataIn,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              chanSel,
  input  logic              ctrlWr,
  output ctrlStrobes_t      strb,
  output logic              snapHeld
);
  localparam int RL_MSB = DATA_W - SEL_W - 1;
  localparam int MODE_MSB = RL_MSB - 2;

  rlMode_e rwMode;
  logic squareQ, rdHiQ, wrHiQ, latchedQ;

  logic [SEL_W-1:0] cwSel;
  logic [1:0] cwRl;
  logic [2:0] cwMode;
  logic cwHit, latchCmd, modeCmd, rdHit, wrHit, readHigh, lastRead;

  assign cwSel  = cpuDataIn[DATA_W-1 -: SEL_W];
  assign cwRl   = cpuDataIn[RL_MSB -: 2];
  assign cwMode = cpuDataIn[MODE_MSB -: 3];

  assign cwHit    = ctrlWr && (cwSel == CHAN_ID);
  assign latchCmd = cwHit && (cwRl == RL_LATCH);
  assign modeCmd  = cwHit && (cwRl != RL_LATCH);
  assign rdHit    = rdStb && chanSel && !ctrlWr;
  assign wrHit    = wrStb && chanSel && !ctrlWr;

  assign readHigh = (rwMode == RL_HIGH) || ((rwMode == RL_BOTH) && rdHiQ);
  assign lastRead = (rwMode != RL_BOTH) || rdHiQ;

  always_comb begin
    strb = '0;
    strb.captureSnap = latchCmd && !latchedQ;
    strb.cancelLoad  = modeCmd;
    strb.selSnap     = latchedQ;
    strb.readHigh    = readHigh;
    strb.squareMode  = squareQ;
    if (wrHit) begin
      unique case (rwMode)
        RL_LOW: begin
          strb.holdLo = 1'b1;
          strb.clearOther = 1'b1;
          strb.armLoad = 1'b1;
        end
        RL_HIGH: begin
          strb.holdHi = 1'b1;
          strb.clearOther = 1'b1;
          strb.armLoad = 1'b1;
        end
        RL_BOTH: begin
          if (!wrHiQ) begin
            strb.holdLo = 1'b1;
          end else begin
            strb.holdHi = 1'b1;
            strb.armLoad = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rwMode   <= RL_BOTH;
      squareQ  <= 1'b0;
      rdHiQ    <= 1'b0;
      wrHiQ    <= 1'b0;
      latchedQ <= 1'b0;
    end else if (modeCmd) begin
      rwMode   <= rlMode_e'(cwRl);
      squareQ  <= (cwMode == SQUARE_CODE);
      rdHiQ    <= 1'b0;
      wrHiQ    <= 1'b0;
      latchedQ <= 1'b0;
    end else begin
      if (latchCmd) latchedQ <= 1'b1;
      if (rdHit) begin
        if (rwMode == RL_BOTH) rdHiQ <= !rdHiQ;
        if (lastRead) latchedQ <= 1'b0;
      end
      if (wrHit && (rwMode == RL_BOTH)) wrHiQ <= !wrHiQ;
    end
  end

  assign snapHeld = latchedQ;

endmodule

// File: rtl/tmr_chan_datapath.sv
`timescale 1ns/1ps
module tmr_chan_datapath
  import tmr_chan_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DATA_W-1:0]     cpuDataIn,
  input  logic                  tmrClk,
  input  logic                  tmrGate,
  input  ctrlStrobes_t          strb,
  output logic [DATA_W-1:0]     cpuDataOut,
  output logic [2*DATA_W-1:0]   countVal,
  output logic [2*DATA_W-1:0]   snapVal,
  output logic                  clkEdge,
  output logic                  loadPend
);
  localparam int CNT_W = 2 * DATA_W;

  logic tmrClkQ;
  logic [CNT_W-1:0] holdReg, stepVal, readSrc;

  assign clkEdge = tmrClk && !tmrClkQ;
  assign stepVal = strb.squareMode ? CNT_W'(2) : CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrClkQ  <= 1'b0;
      countVal <= '0;
      snapVal  <= '0;
      holdReg  <= '0;
      loadPend <= 1'b0;
    end else begin
      tmrClkQ <= tmrClk;

      if (strb.holdLo) begin
        holdReg[DATA_W-1:0] <= cpuDataIn;
        if (strb.clearOther) holdReg[CNT_W-1:DATA_W] <= '0;
      end
      if (strb.holdHi) begin
        holdReg[CNT_W-1:DATA_W] <= cpuDataIn;
        if (strb.clearOther) holdReg[DATA_W-1:0] <= '0;
      end

      if (strb.cancelLoad)      loadPend <= 1'b0;
      else if (strb.armLoad)    loadPend <= 1'b1;
      else if (clkEdge)         loadPend <= 1'b0;

      if (clkEdge) begin
        if (loadPend)     countVal <= holdReg;
        else if (tmrGate) countVal <= countVal - stepVal;
      end

      if (strb.captureSnap) snapVal <= countVal;
    end
  end

  assign readSrc    = strb.selSnap ? snapVal : countVal;
  assign cpuDataOut = strb.readHigh ? readSrc[CNT_W-1:DATA_W] : readSrc[DATA_W-1:0];

endmodule

// File: rtl/timer_channel.sv
`timescale 1ns/1ps
module timer_channel
  import tmr_chan_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W = 2,
  parameter logic [SEL_W-1:0] CHAN_ID = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] cpuDataIn,
  output logic [DATA_W-1:0] cpuDataOut,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              chanSel,
  input  logic              ctrlWr,
  input  logic              tmrClk,
  input  logic              tmrGate
);
  localparam int CNT_W = 2 * DATA_W;

  ctrlStrobes_t strb;
  logic snapHeld, clkEdge, loadPend, squareMode;
  logic [CNT_W-1:0] countVal, snapVal;

  tmr_chan_ctrl #(.DATA_W(DATA_W), .SEL_W(SEL_W), .CHAN_ID(CHAN_ID)) ctrl (
    .clk(clk), .rstN(rstN), .cpuDataIn(cpuDataIn), .rdStb(rdStb), .wrStb(wrStb),
    .chanSel(chanSel), .ctrlWr(ctrlWr), .strb(strb), .snapHeld(snapHeld)
  );

  tmr_chan_datapath #(.DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .cpuDataIn(cpuDataIn), .tmrClk(tmrClk), .tmrGate(tmrGate),
    .strb(strb), .cpuDataOut(cpuDataOut), .countVal(countVal), .snapVal(snapVal),
    .clkEdge(clkEdge), .loadPend(loadPend)
  );

  assign squareMode = strb.squareMode;

endmodule

// File: rtl/timer_channel_checker.sv
`timescale 1ns/1ps
module timer_channel_checker #(
  parameter int DATA_W = 8,
  parameter int SEL_W = 2,
  parameter logic [SEL_W-1:0] CHAN_ID = 1
) (
  input logic                clk,
  input logic                rstN,
  input logic [DATA_W-1:0]   cpuDataIn,
  input logic                ctrlWr,
  input logic                tmrGate,
  input logic                clkEdge,
  input logic                loadPend,
  input logic                squareMode,
  input logic                snapHeld,
  input logic [2*DATA_W-1:0] countVal,
  input logic [2*DATA_W-1:0] snapVal
);
  localparam int RL_MSB = DATA_W - SEL_W - 1;

  logic modeWord;
  assign modeWord = ctrlWr && (cpuDataIn[DATA_W-1 -: SEL_W] == CHAN_ID)
                    && (cpuDataIn[RL_MSB -: 2] != 2'b00);

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clkEdge && tmrGate && !loadPend && !squareMode) |=> (countVal == $past(countVal) - 1'b1));

  assert_step_two_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clkEdge && tmrGate && !loadPend && squareMode) |=> (countVal == $past(countVal) - 2'd2));

  assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!tmrGate && !loadPend) |=> $stable(countVal));

  assert_snap_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    snapHeld |=> $stable(snapVal));

  assert_mode_release_R12: assert property (@(posedge clk) disable iff (!rstN)
    modeWord |=> !snapHeld);

endmodule

bind timer_channel timer_channel_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W), .CHAN_ID(CHAN_ID)) chk (
  .clk(clk), .rstN(rstN), .cpuDataIn(cpuDataIn), .ctrlWr(ctrlWr), .tmrGate(tmrGate),
  .clkEdge(clkEdge), .loadPend(loadPend), .squareMode(squareMode), .snapHeld(snapHeld),
  .countVal(countVal), .snapVal(snapVal)
);

// File: tb/timer_channel_test.sv
`timescale 1ns/1ps
module timer_channel_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] cpuDataIn = '0;
  logic [7:0] cpuDataOut;
  logic rdStb = 1'b0, wrStb = 1'b0, chanSel = 1'b0, ctrlWr = 1'b0;
  logic tmrClk = 1'b0, tmrGate = 1'b0;

  int nChecks = 0;
  int nFail = 0;

  logic [15:0] mCnt = '0, mHold = '0, mSnap = '0;
  logic [1:0] mRw = 2'b11;
  bit mPend = 0, mLatched = 0, mRdHi = 0, mWrHi = 0, mSq = 0;

  always #2.5 clk = ~clk;

  timer_channel uut (
    .clk(clk), .rstN(rstN), .cpuDataIn(cpuDataIn), .cpuDataOut(cpuDataOut),
    .rdStb(rdStb), .wrStb(wrStb), .chanSel(chanSel), .ctrlWr(ctrlWr),
    .tmrClk(tmrClk), .tmrGate(tmrGate)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  function automatic logic [15:0] stepOf(bit sq);
    return sq ? 16'd2 : 16'd1;
  endfunction

  task automatic busCw(input logic [7:0] cw);
    @(negedge clk);
    cpuDataIn = cw; ctrlWr = 1'b1;
    @(negedge clk);
    ctrlWr = 1'b0;
    if (cw[7:6] == 2'd1) begin
      if (cw[5:4] == 2'b00) begin
        if (!mLatched) begin mSnap = mCnt; mLatched = 1; end
      end else begin
        mRw = cw[5:4]; mSq = (cw[3:1] == 3'b011);
        mRdHi = 0; mWrHi = 0; mLatched = 0; mPend = 0;
      end
    end
  endtask

  task automatic busWr(input logic [7:0] d, input bit sel);
    @(negedge clk);
    cpuDataIn = d; wrStb = 1'b1; chanSel = sel;
    @(negedge clk);
    wrStb = 1'b0; chanSel = 1'b0;
    if (sel) begin
      case (mRw)
        2'b01: begin mHold = {8'h00, d}; mPend = 1; end
        2'b10: begin mHold = {d, 8'h00}; mPend = 1; end
        default: begin
          if (!mWrHi) begin mHold[7:0] = d; mWrHi = 1; end
          else begin mHold[15:8] = d; mPend = 1; mWrHi = 0; end
        end
      endcase
    end
  endtask

  task automatic busRd(input string tag);
    logic [15:0] src;
    bit hi, last;
    @(negedge clk);
    rdStb = 1'b1; chanSel = 1'b1;
    #1;
    src = mLatched ? mSnap : mCnt;
    hi = (mRw == 2'b10) || (mRw == 2'b11 && mRdHi);
    check(tag, cpuDataOut, hi ? src[15:8] : src[7:0]);
    @(negedge clk);
    rdStb = 1'b0; chanSel = 1'b0;
    if (mRw == 2'b11) begin last = mRdHi; mRdHi = !mRdHi; end
    else last = 1;
    if (last) mLatched = 0;
  endtask

  task automatic rdWord(input string tag);
    busRd(tag);
    busRd(tag);
  endtask

  task automatic pulse(input bit g);
    @(negedge clk);
    tmrGate = g; tmrClk = 1'b1;
    @(negedge clk);
    tmrClk = 1'b0;
    if (mPend) begin mCnt = mHold; mPend = 0; end
    else if (g) mCnt = mCnt - stepOf(mSq);
  endtask

  task automatic load16(input logic [15:0] v);
    busWr(v[7:0], 1'b1);
    busWr(v[15:8], 1'b1);
    pulse(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rdWord("R1");
    // R10: two-byte load, applied at edge even with gate low
    busCw(8'h74);
    busWr(8'h34, 1'b1); busWr(8'h12, 1'b1);
    pulse(1'b0);
    rdWord("R10");
    busWr(8'h99, 1'b1); pulse(1'b1); rdWord("R10");
    busWr(8'h00, 1'b1); pulse(1'b1); rdWord("R10");
    // R3: wrap
    load16(16'h0001); pulse(1'b1); pulse(1'b1); rdWord("R3");
    // R5: gate low holds
    pulse(1'b0); pulse(1'b0); pulse(1'b0); rdWord("R5");
    // R4: square mode
    busCw(8'h76); load16(16'h0005);
    pulse(1'b1); pulse(1'b1); pulse(1'b1); rdWord("R4");
    // R6 and R8: snapshot, then live after release
    busCw(8'h74); load16(16'h1000);
    busCw(8'h40); pulse(1'b1); pulse(1'b1); pulse(1'b1);
    rdWord("R6");
    rdWord("R8");
    // R7: repeated latch ignored
    busCw(8'h40); pulse(1'b1); busCw(8'h40); pulse(1'b1);
    rdWord("R7");
    // R11: interleaved read and write
    busCw(8'h40);
    busRd("R11"); busWr(8'h78, 1'b1); busRd("R11"); busWr(8'h56, 1'b1);
    pulse(1'b1); rdWord("R11");
    // R12: control word mid-read and mid-load
    busCw(8'h40); busRd("R12"); busCw(8'h74); pulse(1'b1); rdWord("R12");
    busWr(8'h11, 1'b1); busWr(8'h22, 1'b1); busCw(8'h74); pulse(1'b1); rdWord("R12");
    busWr(8'hAB, 1'b1); busCw(8'h74); busWr(8'h01, 1'b1); busWr(8'h02, 1'b1);
    pulse(1'b1); rdWord("R12");
    // R9: single-byte modes
    busCw(8'h54); busWr(8'h42, 1'b1); pulse(1'b1); busRd("R9"); busRd("R9");
    busCw(8'h64); busWr(8'h07, 1'b1); pulse(1'b1); busRd("R9");
    busCw(8'h40); pulse(1'b1); busRd("R9"); busRd("R9");
    busCw(8'h74); busRd("R9"); busRd("R9");
    // R2: other channel, deselected data strobes, ignored bit 0
    busCw(8'hB6); busCw(8'h80); busWr(8'h55, 1'b0); pulse(1'b1); busRd("R2");
    busCw(8'h75); load16(16'h0300); pulse(1'b1); rdWord("R2");

    // mixed random phase
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r <= 2) pulse($urandom_range(0, 3) != 0);
      else if (r == 3) begin
        logic [7:0] cw;
        cw[7:6] = ($urandom_range(0, 5) == 0) ? 2'd2 : 2'd1;
        cw[5:4] = 2'($urandom_range(0, 3));
        cw[3:1] = $urandom_range(0, 1) ? 3'b011 : 3'b010;
        cw[0] = 1'($urandom_range(0, 1));
        busCw(cw);
      end
      else if (r <= 5) busWr(8'($urandom_range(0, 255)), $urandom_range(0, 7) != 0);
      else if (r <= 8) busRd("R9");
      else busCw(8'h40);
    end

    summary();
    $finish;
  end
endmodule